// File: doc/BRIEF.md
# Sequential Word Programming Sequencer

This block drives a streaming program mode for a small byte-addressed nonvolatile array model. A serial front end passes it the bytes of each command and the chip-select level. Each command programs two bytes. The first command carries a start address. Each later command carries only its two data bytes, which go to the next byte pair. Programming begins when chip select is released. Each pair then holds a busy timer for a fixed number of clock cycles.

The block owns three pieces of state: the write-enable latch, the mode flag and the option that drives ready/busy on the serial output. While the mode is active it accepts only three opcodes: the program opcode, a status read and write-disable. The mode ends by itself once the last unprotected pair has been programmed, and it never wraps to the bottom of the array. The array is a register memory. Programming can only clear bits.

Top module: `aai_seq`

## Requirements
- R1: After reset, busy, the write-enable latch, the mode flag and so_oe are all 0, and every array byte reads FFh.
- R2: A one-byte frame with opcode 06h sets the write-enable latch, but only when the mode is off and no program cycle is running.
- R3: A six-byte frame gives opcode ADh, then three address bytes with the most significant byte first, then data bytes D0 and D1. It starts the mode if the write-enable latch is set, the mode is off and the block is not busy. D0 goes to the address with bit 0 cleared and D1 to that address with bit 0 set. Address bits at or above AW are ignored. Without the write-enable latch the frame has no effect.
- R4: A start frame is ignored when the odd byte of its target pair is at or above prot_floor.
- R5: While the mode is active, a three-byte frame of ADh, D0, D1 programs the pair at the previous pair address plus 2. Such a frame is ignored while busy is 1.
- R6: busy reads 1 at the first sample after the clock edge that sees chip select rise on a program frame, and it stays 1 for exactly PROG_CYC cycles.
- R7: Programming stores the bitwise AND of the old byte and the new byte.
- R8: While the mode is active, opcodes 06h, 70h, 80h and all other opcodes except ADh, 05h and 04h have no effect. A 05h frame leaves all state unchanged.
- R9: When the program cycle of the pair ending at the highest unprotected address (or at the top of the array) completes, the mode flag and the write-enable latch both clear. A later continuation frame programs nothing, so there is no wrap.
- R10: A one-byte 04h frame clears the write-enable latch and the mode flag at once. A program cycle already running still completes and writes its pair.
- R11: After a one-byte 70h frame sent outside the mode, so_oe is 1 whenever chip select is low and either the mode is active or busy is 1, and so_val is 0 while busy and 1 when ready. so_oe is 0 while chip select is high.
- R12: A one-byte 80h frame turns the busy output off, but only when sent outside the mode.
- R13: A frame whose byte count does not match its opcode (1 for 04h, 06h, 70h and 80h; 6 for a start; 3 for a continuation) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level, active low; a rise ends a frame |
| byte_vld | input | 1 | One-cycle strobe for a received byte |
| byte_in | input | 8 | Received byte |
| prot_floor | input | AW+1 | Lowest protected address; bytes at or above it are protected |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| busy | output | 1 | Program cycle running |
| wel | output | 1 | Write-enable latch |
| aai_mode | output | 1 | Sequential program mode active |
| so_oe | output | 1 | Serial output driven with ready/busy |
| so_val | output | 1 | Ready/busy level: 0 busy, 1 ready |

## Verification
The assertions assume that byte strobes arrive only while chip select is low, and that chip select stays high for at least one clock between frames so that each rise is seen once. They also assume prot_floor does not change while a frame is being closed. The bench drives every frame through a single task that lowers chip select, sends one strobe per cycle and then raises chip select. It changes prot_floor only between frames. Random opcodes, byte counts and addresses therefore stay inside these limits.

// File: rtl/aai_seq.sv
module aai_seq #(
  parameter int AW       = 6,
  parameter int PROG_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic [AW:0]   prot_floor,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          wel,
  output logic          aai_mode,
  output logic          so_oe,
  output logic          so_val
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(PROG_CYC + 1);

  logic [7:0]    mem [DEPTH];
  logic          cs_q, hw_en, last;
  logic [2:0]    idx;
  logic [7:0]    op, b1, b2, b4, b5;
  logic [AW-1:0] areg, ptr;
  logic [CW-1:0] cnt;

  wire cs_rise = cs_n & ~cs_q;
  wire one_b   = cs_rise && idx == 3'd1;

  wire [AW-1:0] sp   = areg & ~AW'(1);
  wire [AW-1:0] nptr = ptr + AW'(2);
  wire sp_prot = ({1'b0, sp} | (AW+1)'(1)) >= prot_floor;

  wire do_start = cs_rise && op == 8'hAD && idx == 3'd6 && !aai_mode && wel && !busy && !sp_prot;
  wire do_cont  = cs_rise && op == 8'hAD && idx == 3'd3 && aai_mode && !busy;
  wire do_go    = do_start | do_cont;
  wire do_wrdi  = one_b && op == 8'h04;
  wire do_wren  = one_b && op == 8'h06 && !aai_mode && !busy;
  wire do_hwon  = one_b && op == 8'h70 && !aai_mode;
  wire do_hwoff = one_b && op == 8'h80 && !aai_mode;
  wire done     = busy && cnt == '0;

  wire [AW-1:0] go_ptr = do_start ? sp : nptr;
  wire [7:0]    go_d0  = do_start ? b4 : b1;
  wire [7:0]    go_d1  = do_start ? b5 : b2;
  wire go_last = (({1'b0, go_ptr} | (AW+1)'(1)) + (AW+1)'(2)) >= prot_floor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      idx  <= '0;
      op   <= '0;
      b1   <= '0;
      b2   <= '0;
      b4   <= '0;
      b5   <= '0;
      areg <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        if (!cs_rise) idx <= '0;
      end else if (byte_vld) begin
        if (idx != 3'd7) idx <= idx + 3'd1;
        case (idx)
          3'd0: op <= byte_in;
          3'd1: b1 <= byte_in;
          3'd2: b2 <= byte_in;
          3'd4: b4 <= byte_in;
          3'd5: b5 <= byte_in;
          default: ;
        endcase
        if (idx >= 3'd1 && idx <= 3'd3) areg <= AW'({areg, byte_in});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      aai_mode <= 1'b0;
      hw_en    <= 1'b0;
      busy     <= 1'b0;
      last     <= 1'b0;
      cnt      <= '0;
      ptr      <= '0;
    end else begin
      if (busy) begin
        if (done) busy <= 1'b0;
        else      cnt  <= cnt - CW'(1);
      end
      if (done && last) begin
        wel      <= 1'b0;
        aai_mode <= 1'b0;
      end
      if (do_wren)  wel   <= 1'b1;
      if (do_hwon)  hw_en <= 1'b1;
      if (do_hwoff) hw_en <= 1'b0;
      if (do_go) begin
        aai_mode <= 1'b1;
        busy     <= 1'b1;
        cnt      <= CW'(PROG_CYC - 1);
        ptr      <= go_ptr;
        last     <= go_last;
      end
      if (do_wrdi) begin
        wel      <= 1'b0;
        aai_mode <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_go) begin
      mem[go_ptr]            <= mem[go_ptr] & go_d0;
      mem[go_ptr | AW'(1)]   <= mem[go_ptr | AW'(1)] & go_d1;
    end
  end

  assign rd_data = mem[rd_addr];
  assign so_oe   = hw_en & ~cs_n & (aai_mode | busy);
  assign so_val  = ~busy;
endmodule

// File: rtl/aai_seq_chk.sv
module aai_seq_chk #(
  parameter int PROG_CYC = 8,
  localparam int CW = $clog2(PROG_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          busy,
  input logic          wel,
  input logic          aai_mode,
  input logic          so_oe,
  input logic          so_val,
  input logic          hw_en,
  input logic [CW-1:0] cnt
);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> busy);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == '0 |=> !busy);
  // R3
  start_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_mode) |-> $past(wel));
  // R5
  prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> aai_mode);
  // R9
  exit_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai_mode) |-> !wel);
  // R11
  so_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !cs_n);
  // R11
  so_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe && busy |-> !so_val);
  // R12
  hw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_en) |-> !$past(aai_mode));
endmodule

bind aai_seq aai_seq_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .wel(wel),
  .aai_mode(aai_mode), .so_oe(so_oe), .so_val(so_val), .hw_en(hw_en), .cnt(cnt)
);

// File: tb/aai_seq_test.sv
module aai_seq_test;
  localparam int AW = 6;
  localparam int P  = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic [AW:0] prot_floor = 7'd64;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, wel, aai_mode, so_oe, so_val;

  aai_seq #(.AW(AW), .PROG_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .prot_floor(prot_floor), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .wel(wel), .aai_mode(aai_mode), .so_oe(so_oe), .so_val(so_val)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] fb [6];
  logic [7:0] exp_mem [DEPTH];
  logic m_wel, m_mode, m_hw, m_busy, m_last;
  logic [AW-1:0] m_ptr;
  logic pr_oe, pr_val;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(busy == m_busy, {tag, " busy"}, busy, m_busy);
    chk(wel == m_wel, {tag, " wel"}, wel, m_wel);
    chk(aai_mode == m_mode, {tag, " mode"}, aai_mode, m_mode);
  endtask

  task automatic chk_byte(input int a, input string tag);
    rd_addr = AW'(a);
    #1;
    chk(rd_data == exp_mem[a], tag, rd_data, exp_mem[a]);
  endtask

  task automatic chk_mem(input string tag);
    int errs = 0, fa = -1;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data != exp_mem[a]) begin
        errs++;
        if (fa < 0) fa = a;
      end
    end
    if (fa < 0) chk(1'b1, tag, 0, 0);
    else begin
      rd_addr = AW'(fa);
      #1;
      chk(1'b0, {tag, " array"}, rd_data, exp_mem[fa]);
    end
  endtask

  task automatic prog(input logic [AW-1:0] p, input logic [7:0] d0, input logic [7:0] d1);
    exp_mem[p]   = exp_mem[p] & d0;
    exp_mem[p+1] = exp_mem[p+1] & d1;
    m_ptr  = p;
    m_busy = 1'b1;
    m_last = (int'(p) + 3) >= int'(prot_floor);
  endtask

  task automatic model(input int n);
    logic [7:0] op;
    logic [AW-1:0] sp;
    op = fb[0];
    if (op == 8'h04 && n == 1) begin m_wel = 0; m_mode = 0; end
    else if (op == 8'h06 && n == 1) begin if (!m_mode && !m_busy) m_wel = 1; end
    else if (op == 8'h70 && n == 1) begin if (!m_mode) m_hw = 1; end
    else if (op == 8'h80 && n == 1) begin if (!m_mode) m_hw = 0; end
    else if (op == 8'hAD && !m_busy) begin
      if (!m_mode && n == 6 && m_wel) begin
        sp = {fb[3][AW-1:1], 1'b0};
        if (int'(sp) + 1 < int'(prot_floor)) begin
          prog(sp, fb[4], fb[5]);
          m_mode = 1;
        end
      end else if (m_mode && n == 3) begin
        prog(m_ptr + AW'(2), fb[1], fb[2]);
      end
    end
  endtask

  task automatic frame(input int n);
    @(negedge clk);
    cs_n = 1'b0;
    #1;
    pr_oe = so_oe;
    pr_val = so_val;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in = fb[i];
    end
    @(negedge clk);
    byte_vld = 1'b0;
    cs_n = 1'b1;
    model(n);
    @(negedge clk);
  endtask

  task automatic wait_done();
    if (m_busy) begin
      repeat (P + 1) @(negedge clk);
      m_busy = 0;
      if (m_last) begin m_wel = 0; m_mode = 0; end
    end
  endtask

  task automatic one(input logic [7:0] op);
    fb[0] = op;
    frame(1);
  endtask

  task automatic start(input logic [7:0] a2, input logic [7:0] a1, input logic [7:0] a0,
                       input logic [7:0] d0, input logic [7:0] d1);
    fb[0] = 8'hAD; fb[1] = a2; fb[2] = a1; fb[3] = a0; fb[4] = d0; fb[5] = d1;
    frame(6);
  endtask

  task automatic cont(input logic [7:0] d0, input logic [7:0] d1);
    fb[0] = 8'hAD; fb[1] = d0; fb[2] = d1;
    frame(3);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    m_wel = 0; m_mode = 0; m_hw = 0; m_busy = 0; m_last = 0; m_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_state("R1 reset");
    chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
    chk_mem("R1 erased");

    // R3: no latch, start ignored
    start(8'h00, 8'h00, 8'h10, 8'h12, 8'h34); wait_done();
    chk_state("R3 no wel");
    chk_mem("R3 no wel");

    // R2
    one(8'h06);
    chk(wel == 1'b1, "R2 wren", wel, 1);

    // R3 + R6: upper address bits ignored, odd address aligned down
    start(8'hFF, 8'hFF, 8'h11, 8'hA5, 8'h3C);
    chk(busy == 1'b1, "R6 busy first", busy, 1);
    chk(aai_mode == 1'b1, "R3 mode set", aai_mode, 1);
    repeat (P - 1) @(negedge clk);
    chk(busy == 1'b1, "R6 busy last", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R6 busy end", busy, 0);
    m_busy = 0;
    chk_byte(16, "R3 even byte");
    chk_byte(17, "R3 odd byte");
    chk(exp_mem[16] == 8'hA5 && exp_mem[17] == 8'h3C, "R3 model", exp_mem[16], 8'hA5);

    // R5
    cont(8'h0F, 8'hF0); wait_done();
    chk_byte(18, "R5 next pair lo");
    chk_byte(19, "R5 next pair hi");

    // R8: status read changes nothing
    one(8'h05);
    chk_state("R8 status read");

    // R13: short continuation
    fb[0] = 8'hAD; fb[1] = 8'h11; frame(2);
    chk_mem("R13 short frame");

    // R8: 70h in mode ignored, junk ignored
    one(8'h70);
    fb[0] = 8'h20; fb[1] = 8'h00; fb[2] = 8'h00; frame(3);
    cont(8'h77, 8'h88);
    chk(pr_oe == 1'b0, "R8 70h ignored in mode", pr_oe, 0);
    wait_done();
    chk_mem("R8 junk ignored");

    // R5: continuation while busy ignored
    cont(8'h01, 8'h02);
    cont(8'h03, 8'h04);
    wait_done();
    chk_byte(24, "R5 busy cont ignored");
    chk_mem("R5 busy");

    // R10
    cont(8'h55, 8'h66);
    one(8'h04);
    chk(wel == 1'b0, "R10 wel clear", wel, 0);
    chk(aai_mode == 1'b0, "R10 mode clear", aai_mode, 0);
    chk(busy == 1'b1, "R10 busy kept", busy, 1);
    wait_done();
    chk_byte(24, "R10 pair written");
    chk_state("R10 after");

    // R11
    one(8'h70);
    chk(so_oe == 1'b0, "R11 cs high", so_oe, 0);
    one(8'h06);
    start(8'h00, 8'h00, 8'h20, 8'hC3, 8'h3C);
    one(8'h05);
    chk(pr_oe == 1'b1 && pr_val == 1'b0, "R11 busy drive", {pr_oe, pr_val}, 2'b10);
    wait_done();
    one(8'h05);
    chk(pr_oe == 1'b1 && pr_val == 1'b1, "R11 ready drive", {pr_oe, pr_val}, 2'b11);
    chk(so_oe == 1'b0, "R11 release", so_oe, 0);

    // R12
    one(8'h80);
    one(8'h05);
    chk(pr_oe == 1'b1, "R12 80h ignored in mode", pr_oe, 1);
    one(8'h04);
    one(8'h80);
    one(8'h06);
    start(8'h00, 8'h00, 8'h22, 8'h5A, 8'h5A);
    one(8'h05);
    chk(pr_oe == 1'b0, "R12 off", pr_oe, 0);
    wait_done();
    one(8'h04);

    // R7
    one(8'h06);
    start(8'h00, 8'h00, 8'h10, 8'h0F, 8'hF0);
    wait_done();
    chk(exp_mem[16] == 8'h05 && exp_mem[17] == 8'h30, "R7 model", exp_mem[16], 8'h05);
    chk_byte(16, "R7 and lo");
    chk_byte(17, "R7 and hi");
    one(8'h04);

    // R4
    prot_floor = 7'd40;
    one(8'h06);
    start(8'h00, 8'h00, 8'h28, 8'h00, 8'h00); wait_done();
    chk_state("R4 protected start");
    // R9
    start(8'h00, 8'h00, 8'h24, 8'h11, 8'h22); wait_done();
    cont(8'h33, 8'h44); wait_done();
    chk(aai_mode == 1'b0 && wel == 1'b0, "R9 auto exit", {aai_mode, wel}, 0);
    cont(8'h00, 8'h00); wait_done();
    chk_mem("R9 no program after exit");
    prot_floor = 7'd37;
    one(8'h06);
    start(8'h00, 8'h00, 8'h24, 8'h00, 8'h00); wait_done();
    chk(aai_mode == 1'b0, "R4 odd floor", aai_mode, 0);
    one(8'h04);

    // R9: top of array, no wrap
    prot_floor = 7'd64;
    one(8'h06);
    start(8'h00, 8'h00, 8'h3C, 8'hE1, 8'hE2); wait_done();
    cont(8'hE3, 8'hE4); wait_done();
    chk_state("R9 top exit");
    cont(8'h00, 8'h00); wait_done();
    chk_byte(0, "R9 no wrap");
    chk_mem("R9 top");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int r;
      if (it % 15 == 0) prot_floor = 7'($urandom_range(8, 64));
      r = $urandom_range(0, 9);
      case (r)
        0, 1: one(8'h06);
        2, 3: start(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        4, 5: cont(8'($urandom), 8'($urandom));
        6: one(8'h04);
        7: one(8'h05);
        default: begin
          int n;
          n = $urandom_range(1, 6);
          for (int k = 0; k < 6; k++) fb[k] = 8'($urandom);
          if (r == 9) fb[0] = 8'hAD;
          frame(n);
        end
      endcase
      wait_done();
      chk_state("R8 R13 random");
      if (it % 10 == 9) chk_mem("R3 R5 R7 random");
    end
    chk_mem("R7 final");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule